// File: doc/BRIEF.md
# Parallel SPI Converter Capture Front End

This block reads a bank of serial analog-to-digital converters at the same time. One control sequencer produces a single serial clock and chip-select waveform for every channel. Each channel has its own serial data return line and its own shift register and result register. One start strobe runs one conversion frame on all channels together. At the end of the frame, every channel's result updates on the same edge and a one-clock valid pulse marks the new data.

The serial clock and chip-select that leave the block are not taken from one shared register. Each channel drives its pins from a dedicated pair of output flops. Each pair has a synchronous clear. After reset, a thermometer register fills with ones, one bit per clock. Bit k of that register releases channel k from clear, so the channels leave the cleared state in order. This makes the per-channel flops differ in logic, so a netlist optimiser cannot merge them into one shared flop. The thermometer serves no other purpose. The sequencer ignores start requests until the thermometer is full.

Top module: `spi_par_capture`

## Requirements
- R1: While reset is held, and on the first clock after release, every chip-select output is high (inactive) and every serial clock output is low. `busy_o` and `valid_o` are low and every result is zero.
- R2: A start strobe is accepted only once all N_CH thermometer bits are one. Counting clock edges from reset release, a strobe sampled on edge N_CH+1 or later starts a frame. A strobe sampled on any earlier edge is ignored, and `busy_o` stays low.
- R3: In a frame, chip-select stays low for exactly DATA_W*SCLK_DIV clocks. The serial clock gives exactly DATA_W rising edges during that time. The serial clock is low whenever chip-select is high.
- R4: The serial clock period is SCLK_DIV system clocks, with SCLK_DIV/2 clocks high per period. SCLK_DIV must be even and at least 2.
- R5: Each channel shifts in its own data line, most significant bit first. A bit is sampled on the system clock edge that drives that channel's serial clock output high. A frame's DATA_W bits form that channel's result, at bits [c*DATA_W +: DATA_W] of `result_o`.
- R6: All results update on the same edge. `valid_o` is high for exactly one clock, DATA_W*SCLK_DIV clocks after the edge that accepted the start. Results do not change at any other time.
- R7: `busy_o` goes high on the edge that accepts a start. It goes low on the same edge that raises `valid_o`.
- R8: A start strobe that arrives while `busy_o` is high has no effect. The frame length, the results and the valid count stay the same as for an undisturbed frame.
- R9: While a frame runs, all channels' serial clock outputs are equal to each other, and all chip-select outputs are equal to each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion frame |
| miso_i | input | N_CH | Serial data from each converter |
| sclk_o | output | N_CH | Serial clock, one per channel |
| cs_n_o | output | N_CH | Chip-select, active low, one per channel |
| result_o | output | N_CH*DATA_W | Packed per-channel results; channel c at [c*DATA_W +: DATA_W] |
| valid_o | output | 1 | One-clock pulse when the results update |
| busy_o | output | 1 | Frame in progress |

## Verification
The hardest case to reach is a start strobe that arrives while the thermometer is still filling. After reset release the pins look the same whether a channel is cleared or released, so the only visible effect is whether the strobe is accepted. The bench therefore re-applies reset once for each offset from zero to a few clocks past N_CH. At each offset it pulses start and checks that `busy_o` rises exactly when the offset reaches N_CH. A converter model on each line shifts out its own value, falling-edge aligned. The frames use all-zero, all-one, walking-one, walking-zero and arithmetic patterns. One frame receives an extra start strobe in the middle.

// File: rtl/spi_cap_pkg.sv
package spi_cap_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SHIFT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pwr_thermo.sv
module pwr_thermo #(
  parameter int N_CH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [N_CH-1:0] therm_o
);
  logic [N_CH-1:0] therm_q;

  generate
    if (N_CH > 1) begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) therm_q <= '0;
        else         therm_q <= {therm_q[N_CH-2:0], 1'b1};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) therm_q <= '0;
        else         therm_q <= 1'b1;
      end
    end
  endgenerate

  assign therm_o = therm_q;
endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_cap_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SCLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic start_i,
  output logic sclk_o,
  output logic cs_n_o,
  output logic sample_o,
  output logic frame_end_o,
  output logic busy_o
);
  localparam int HALF  = SCLK_DIV / 2;
  localparam int PH_W  = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  seq_state_e       state_q;
  logic [PH_W-1:0]  ph_q;
  logic [BIT_W-1:0] bit_q;
  logic             ph_last, bit_last;

  assign ph_last  = (ph_q == PH_W'(SCLK_DIV - 1));
  assign bit_last = (bit_q == BIT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i && ready_i) begin
            state_q <= SEQ_SHIFT;
            ph_q    <= '0;
            bit_q   <= '0;
          end
        end
        SEQ_SHIFT: begin
          if (ph_last) begin
            ph_q <= '0;
            if (bit_last) state_q <= SEQ_IDLE;
            else          bit_q   <= bit_q + 1'b1;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o      = (state_q == SEQ_SHIFT);
    cs_n_o      = !busy_o;
    sclk_o      = busy_o && (ph_q >= PH_W'(HALF));
    sample_o    = busy_o && (ph_q == PH_W'(HALF));
    frame_end_o = busy_o && ph_last && bit_last;
  end
endmodule

// File: rtl/chan_out_reg.sv
module chan_out_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic release_i,
  input  logic sclk_i,
  input  logic cs_n_i,
  output logic sclk_o,
  output logic cs_n_o
);
  // sync clear driven only by the thermometer bit keeps each copy distinct
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_o <= 1'b0;
      cs_n_o <= 1'b1;
    end else if (!release_i) begin
      sclk_o <= 1'b0;
      cs_n_o <= 1'b1;
    end else begin
      sclk_o <= sclk_i;
      cs_n_o <= cs_n_i;
    end
  end
endmodule

// File: rtl/chan_capture.sv
module chan_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miso_i,
  input  logic              sample_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] shift_q, shift_d;

  // load takes the post-sample value so the last bit may land on the load edge
  always_comb begin
    shift_d = shift_q;
    if (sample_i) shift_d = {shift_q[DATA_W-2:0], miso_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      result_o <= '0;
    end else begin
      shift_q <= shift_d;
      if (load_i) result_o <= shift_d;
    end
  end
endmodule

// File: rtl/spi_par_capture.sv
module spi_par_capture #(
  parameter int N_CH     = 16,
  parameter int DATA_W   = 16,
  parameter int SCLK_DIV = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [N_CH-1:0]          miso_i,
  output logic [N_CH-1:0]          sclk_o,
  output logic [N_CH-1:0]          cs_n_o,
  output logic [N_CH*DATA_W-1:0]   result_o,
  output logic                     valid_o,
  output logic                     busy_o
);
  logic [N_CH-1:0] therm;
  logic            ready;
  logic            sclk_int, cs_n_int, sample, frame_end;

  pwr_thermo #(.N_CH(N_CH)) u_thermo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .therm_o(therm)
  );

  assign ready = &therm;

  spi_seq #(.DATA_W(DATA_W), .SCLK_DIV(SCLK_DIV)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_i    (ready),
    .start_i    (start_i),
    .sclk_o     (sclk_int),
    .cs_n_o     (cs_n_int),
    .sample_o   (sample),
    .frame_end_o(frame_end),
    .busy_o     (busy_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    chan_out_reg u_out (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .release_i(therm[c]),
      .sclk_i   (sclk_int),
      .cs_n_i   (cs_n_int),
      .sclk_o   (sclk_o[c]),
      .cs_n_o   (cs_n_o[c])
    );

    chan_capture #(.DATA_W(DATA_W)) u_cap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .miso_i  (miso_i[c]),
      .sample_i(sample),
      .load_i  (frame_end),
      .result_o(result_o[c*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= frame_end;
  end
endmodule

// File: rtl/spi_par_capture_chk.sv
module spi_par_capture_chk #(
  parameter int N_CH     = 16,
  parameter int DATA_W   = 16,
  parameter int SCLK_DIV = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic [N_CH-1:0]        sclk_o,
  input logic [N_CH-1:0]        cs_n_o,
  input logic [N_CH*DATA_W-1:0] result_o,
  input logic                   valid_o,
  input logic                   busy_o
);
  localparam int CYC_W = $clog2(N_CH + 2) + 1;
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cyc_q <= '0;
    else if (cyc_q <= CYC_W'(N_CH))     cyc_q <= cyc_q + 1'b1;
  end

  p_no_early_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cyc_q > CYC_W'(N_CH)));

  p_idle_sclk_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_o & sclk_o) == '0);

  p_valid_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_result_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));

  p_busy_ends_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid_o);

  p_start_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !valid_o) |=> (busy_o || valid_o));

  p_lockstep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ((sclk_o == '0 || sclk_o == '1) && (cs_n_o == '0 || cs_n_o == '1)));
endmodule

bind spi_par_capture spi_par_capture_chk #(
  .N_CH(N_CH), .DATA_W(DATA_W), .SCLK_DIV(SCLK_DIV)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .sclk_o  (sclk_o),
  .cs_n_o  (cs_n_o),
  .result_o(result_o),
  .valid_o (valid_o),
  .busy_o  (busy_o)
);

// File: tb/sim_spi_par_capture.sv
module sim_spi_par_capture;
  localparam int N_CH     = 16;
  localparam int DATA_W   = 16;
  localparam int SCLK_DIV = 4;
  localparam int FRAME    = DATA_W * SCLK_DIV;

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   start_i = 1'b0;
  logic [N_CH-1:0]        miso_i = '0;
  logic [N_CH-1:0]        sclk_o, cs_n_o;
  logic [N_CH*DATA_W-1:0] result_o;
  logic                   valid_o, busy_o;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] vals [N_CH];

  always #10 clk_i = ~clk_i;

  spi_par_capture #(.N_CH(N_CH), .DATA_W(DATA_W), .SCLK_DIV(SCLK_DIV)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .miso_i(miso_i),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .result_o(result_o),
    .valid_o(valid_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // converter model plus pin timing monitor, all at the falling clock edge
  int  idx = -1;
  bit  p_cs = 1'b1, p_sclk = 1'b0;
  int  cyc = 0, cs_run = 0, rises = 0, hi_run = 0, last_rise = 0;
  bit  lock_err = 1'b0;

  always @(negedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      idx = -1; cs_run = 0; rises = 0; hi_run = 0; lock_err = 1'b0;
    end else begin
      if (!cs_n_o[0]) begin
        if (!(sclk_o == '0 || sclk_o == '1) || !(cs_n_o == '0 || cs_n_o == '1)) lock_err = 1'b1;
        cs_run++;
      end
      if (cs_n_o[0] && sclk_o[0]) chk(1'b0, "R3 sclk high while deselected", 1, 0);
      if (sclk_o[0] && !p_sclk) begin
        if (rises > 0) chk(cyc - last_rise == SCLK_DIV, "R4 sclk period", cyc - last_rise, SCLK_DIV);
        last_rise = cyc;
        rises++;
      end
      if (sclk_o[0]) hi_run++;
      else if (hi_run > 0) begin
        chk(hi_run == SCLK_DIV / 2, "R4 sclk high time", hi_run, SCLK_DIV / 2);
        hi_run = 0;
      end
      if (cs_n_o[0] && !p_cs) begin
        chk(cs_run == FRAME, "R3 cs low length", cs_run, FRAME);
        chk(rises == DATA_W, "R3 sclk rise count", rises, DATA_W);
        chk(!lock_err, "R9 channel lockstep", lock_err, 0);
        cs_run = 0; rises = 0; lock_err = 1'b0;
      end
      if (p_cs && !cs_n_o[0]) begin
        for (int c = 0; c < N_CH; c++) miso_i[c] = vals[c][DATA_W-1];
        idx = DATA_W - 2;
      end else if (p_sclk && !sclk_o[0] && !cs_n_o[0] && idx >= 0) begin
        for (int c = 0; c < N_CH; c++) miso_i[c] = vals[c][idx];
        idx--;
      end
    end
    p_cs   = cs_n_o[0];
    p_sclk = sclk_o[0];
  end

  task automatic do_reset();
    rst_ni  = 1'b0;
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(cs_n_o == '1 && sclk_o == '0, "R1 pins in reset", {cs_n_o, sclk_o}, {N_CH{1'b1}});
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_n_o == '1 && sclk_o == '0, "R1 pins after release", {cs_n_o, sclk_o}, {N_CH{1'b1}});
    chk(!busy_o && !valid_o, "R1 flags after release", {busy_o, valid_o}, 0);
    chk(result_o == '0, "R1 results cleared", result_o[63:0], 0);
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((busy_o || valid_o) && n < 4 * FRAME) begin @(negedge clk_i); n++; end
    repeat (SCLK_DIV) @(negedge clk_i);
  endtask

  // one frame; extra start strobe injected mid-frame when poke is set
  task automatic run_frame(input bit poke);
    int n = 0;
    int vcount = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o, "R7 busy after accept", busy_o, 1);
    while (!valid_o && n < 4 * FRAME) begin
      @(negedge clk_i);
      n++;
      start_i = poke && (n == 3 * SCLK_DIV);
      if (!valid_o && !busy_o) chk(1'b0, "R7 busy dropped early", n, FRAME);
    end
    start_i = 1'b0;
    chk(n == FRAME, poke ? "R8 frame length with extra start" : "R6 valid latency", n, FRAME);
    chk(!busy_o, "R7 busy low with valid", busy_o, 0);
    for (int c = 0; c < N_CH; c++)
      chk(result_o[c*DATA_W +: DATA_W] == vals[c],
          poke ? "R8 result with extra start" : "R5 channel result",
          result_o[c*DATA_W +: DATA_W], vals[c]);
    for (int k = 0; k < FRAME + 4; k++) begin
      @(negedge clk_i);
      if (valid_o) vcount++;
      if (busy_o) vcount += 100;
    end
    chk(vcount == 0, poke ? "R8 no second frame" : "R6 single valid pulse", vcount, 0);
  endtask

  initial begin
    for (int c = 0; c < N_CH; c++) vals[c] = '0;

    // R2: start offset sweep across the thermometer fill
    for (int j = 0; j <= N_CH + 4; j++) begin
      do_reset();
      repeat (j - 1 < 0 ? 0 : j - 1) @(negedge clk_i);
      if (j == 0) begin
        // offset 0: strobe already present on the first edge after release
        rst_ni = 1'b0; @(negedge clk_i);
        start_i = 1'b1; rst_ni = 1'b1;
        @(negedge clk_i);
      end else begin
        start_i = 1'b1;
        @(negedge clk_i);
      end
      start_i = 1'b0;
      chk(busy_o == (j >= N_CH), "R2 start vs warm-up offset", busy_o, j >= N_CH);
      if (j < N_CH) chk(cs_n_o == '1, "R2 ignored start leaves cs high", cs_n_o, {N_CH{1'b1}});
      wait_idle();
    end

    do_reset();
    repeat (N_CH + 2) @(negedge clk_i);

    for (int p = 0; p < 10; p++) begin
      for (int c = 0; c < N_CH; c++) begin
        case (p)
          0: vals[c] = '0;
          1: vals[c] = '1;
          2: vals[c] = DATA_W'(1) << (c % DATA_W);
          3: vals[c] = ~(DATA_W'(1) << (c % DATA_W));
          4: vals[c] = DATA_W'(16'hA5C3 >> c) | DATA_W'(16'hA5C3 << (DATA_W - c));
          default: vals[c] = DATA_W'(c * 16'h1357 + p * 16'h0F1B);
        endcase
      end
      run_frame(p == 6);
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule